// File: doc/BRIEF.md
# Descriptor Store Access Guard

This block holds the descriptor bytes of a USB device controller in a 384-byte, byte-wide RAM. The RAM appears in the CPU register window at byte addresses 0x0500 to 0x067F. A small phase tracker decides when the CPU may read or write those bytes. Access is open from power-up until the first bus reset. After that, it is open only while a SET_DESCRIPTOR control request is being handled.

The RAM feeds the controller's working descriptor data through a reload sequencer. The sequencer streams every byte out once, in address order. It starts by itself on each bus reset, and it can be started again by an init-descriptor command after software has rewritten the store. A control bit can make the block request STALL on its own during a SET_DESCRIPTOR request instead of leaving that to software.

Top module: `desc_ram_guard`

## Requirements
- R1: After synchronous reset: the access window is open (pre-bus-reset phase); the auto-stall bit is 0; `stall_req`, `reload_busy`, `init_done` and `ld_valid` are 0; and `cpu_rdata` is 0x00.
- R2: Before the first `bus_reset`, a write to any address from 0x0500 to 0x067F stores its byte at offset address-0x0500. A read of that address returns the byte on `cpu_rdata` in the cycle after `cpu_rd` is sampled.
- R3: After a `bus_reset` and outside a SET_DESCRIPTOR window, RAM writes are ignored and RAM reads return 0x00.
- R4: After the first bus reset, a `setup_evt` with `req_code` = 0x07 opens the access window. A setup with any other code leaves it closed. A pulse on `eop_access` closes it.
- R5: A `bus_reset` starts a reload. The reload presents bytes 0 to 383 in ascending order, one per cycle, on `ld_valid`/`ld_index`/`ld_data`, each with the RAM content of that index.
- R6: `init_cmd` starts the same reload. `init_done` is a one-cycle pulse that coincides with the last byte, 384 cycles after the cycle that sampled the start.
- R7: `reload_busy` is high for the whole reload. An `init_cmd` that arrives while busy is ignored, and the running reload keeps its original timing.
- R8: While `reload_busy` is high, CPU RAM writes are ignored and CPU RAM reads return 0x00, even with the window open.
- R9: A control register at 0x07E8 holds the auto-stall bit in bit 0, with reset value 0. It can be written and read at any time, and its bits 7:1 read as 0.
- R10: `stall_req` equals the auto-stall bit while a SET_DESCRIPTOR window is open, and is 0 otherwise.
- R11: Addresses outside 0x0500 to 0x067F and other than 0x07E8 ignore writes and read 0x00. A `bus_reset` during a reload restarts it from byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| setup_evt | input | 1 | Setup-received event strobe |
| req_code | input | 8 | Request code of the current setup |
| bus_reset | input | 1 | USB bus reset detected strobe |
| eop_access | input | 1 | Strobe for a CPU access to the end-of-packet register |
| init_cmd | input | 1 | Init-descriptor command strobe |
| stall_req | output | 1 | Automatic STALL request |
| reload_busy | output | 1 | Reload in progress |
| init_done | output | 1 | One-cycle pulse with the last reloaded byte |
| ld_valid | output | 1 | Reload byte valid |
| ld_index | output | 9 | Reload byte index |
| ld_data | output | 8 | Reload byte value |

## Verification
On every cycle, the assertions check these properties:
- the window opens only on a SET_DESCRIPTOR setup and closes on an end-of-packet access;
- a bus reset leaves the pre-reset phase;
- a refused RAM read returns zero;
- a reload index only steps by one, even when a command arrives while busy;
- a bus reset restarts the index at zero;
- `init_done` is a single pulse that follows a busy cycle.

Some behaviours can only be shown by the bench's scenarios:
- bytes written through the CPU actually come back, both over the CPU read path and in the reload stream;
- the exact 384-cycle reload length, measured with and without an ignored command or a restart;
- that writes refused while busy or outside the window leave the stored bytes unchanged.

// File: rtl/descg_pkg.sv
package descg_pkg;
  typedef enum logic [1:0] {
    PH_PRE     = 2'd0,
    PH_IDLE    = 2'd1,
    PH_SETDESC = 2'd2
  } phase_t;
endpackage

// File: rtl/descg_mem.sv
module descg_mem #(
  parameter int DEPTH = 384,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/descg_phase.sv
module descg_phase
  import descg_pkg::*;
#(
  parameter logic [7:0] SETDESC_CODE = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_reset,
  input  logic       setup_evt,
  input  logic [7:0] req_code,
  input  logic       eop_access,
  output logic       win_open,
  output logic       in_setdesc
);
  phase_t ph_q, ph_d;
  logic   is_setdesc;

  assign is_setdesc = setup_evt && (req_code == SETDESC_CODE);

  always_comb begin
    ph_d = ph_q;
    if (bus_reset) ph_d = PH_IDLE;
    else begin
      unique case (ph_q)
        PH_PRE:     ph_d = PH_PRE;
        PH_IDLE:    if (is_setdesc) ph_d = PH_SETDESC;
        PH_SETDESC: if (eop_access || (setup_evt && !is_setdesc)) ph_d = PH_IDLE;
        default:    ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_PRE;
    else     ph_q <= ph_d;
  end

  assign in_setdesc = (ph_q == PH_SETDESC);
  assign win_open   = (ph_q == PH_PRE) || in_setdesc;

  AST_WIN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(in_setdesc) |-> $past(setup_evt && req_code == SETDESC_CODE)); // R4
  AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (in_setdesc && eop_access) |=> !in_setdesc); // R4
  AST_PRE_ENDS: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (ph_q != PH_PRE)); // R3
endmodule

// File: rtl/descg_reload.sv
module descg_reload #(
  parameter int DEPTH = 384,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_cmd,
  input  logic          start_rst,
  output logic          busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          ld_valid,
  output logic [AW-1:0] ld_index,
  output logic          init_done
);
  logic [AW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      ld_valid  <= 1'b0;
      ld_index  <= '0;
      init_done <= 1'b0;
    end else begin
      ld_valid  <= busy;
      ld_index  <= idx;
      init_done <= busy && (idx == LAST);
      if (start_rst || (start_cmd && !busy)) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST) busy <= 1'b0;
        else             idx  <= idx + 1'b1;
      end
    end
  end

  assign rd_en   = busy;
  assign rd_addr = idx;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    init_done |=> !init_done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    init_done |-> $past(busy)); // R6
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start_cmd && !start_rst && idx != LAST) |=> (busy && idx == AW'($past(idx) + 1'b1))); // R7
  AST_RST_RESTART: assert property (@(posedge clk) disable iff (rst)
    start_rst |=> (busy && idx == '0)); // R11
endmodule

// File: rtl/desc_ram_guard.sv
module desc_ram_guard
  import descg_pkg::*;
#(
  parameter int          DEPTH        = 384,
  parameter logic [15:0] RAM_BASE     = 16'h0500,
  parameter logic [15:0] CTRL_ADDR    = 16'h07E8,
  parameter logic [7:0]  SETDESC_CODE = 8'h07,
  localparam int AW = $clog2(DEPTH),
  localparam logic [15:0] RAM_TOP = RAM_BASE + 16'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          setup_evt,
  input  logic [7:0]    req_code,
  input  logic          bus_reset,
  input  logic          eop_access,
  input  logic          init_cmd,
  output logic          stall_req,
  output logic          reload_busy,
  output logic          init_done,
  output logic          ld_valid,
  output logic [AW-1:0] ld_index,
  output logic [7:0]    ld_data
);
  logic          win_open, in_setdesc;
  logic          busy, rl_re;
  logic [AW-1:0] rl_addr;
  logic          hit_ram, hit_ctrl, access_ok;
  logic [AW-1:0] ram_off;
  logic          mem_we, cpu_re, mem_re;
  logic [AW-1:0] mem_raddr;
  logic [7:0]    mem_q;
  logic          auto_stall, rsel_ram;
  logic [7:0]    ctrl_q;

  descg_phase #(.SETDESC_CODE(SETDESC_CODE)) u_phase (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .setup_evt(setup_evt),
    .req_code(req_code), .eop_access(eop_access),
    .win_open(win_open), .in_setdesc(in_setdesc)
  );

  descg_reload #(.DEPTH(DEPTH)) u_reload (
    .clk(clk), .rst(rst), .start_cmd(init_cmd), .start_rst(bus_reset),
    .busy(busy), .rd_en(rl_re), .rd_addr(rl_addr),
    .ld_valid(ld_valid), .ld_index(ld_index), .init_done(init_done)
  );

  assign hit_ram   = (cpu_addr >= RAM_BASE) && (cpu_addr <= RAM_TOP);
  assign hit_ctrl  = (cpu_addr == CTRL_ADDR);
  assign ram_off   = AW'(cpu_addr - RAM_BASE);
  assign access_ok = win_open && !busy;
  assign mem_we    = cpu_wr && hit_ram && access_ok;
  assign cpu_re    = cpu_rd && hit_ram && access_ok;
  assign mem_re    = rl_re || cpu_re;
  assign mem_raddr = rl_re ? rl_addr : ram_off;

  descg_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ram_off), .wdata(cpu_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_stall <= 1'b0;
      rsel_ram   <= 1'b0;
      ctrl_q     <= 8'h00;
    end else begin
      if (cpu_wr && hit_ctrl) auto_stall <= cpu_wdata[0];
      rsel_ram <= cpu_re;
      ctrl_q   <= (cpu_rd && hit_ctrl) ? {7'b0, auto_stall} : 8'h00;
    end
  end

  assign cpu_rdata   = rsel_ram ? mem_q : ctrl_q;
  assign ld_data     = mem_q;
  assign stall_req   = auto_stall && in_setdesc;
  assign reload_busy = busy;

  AST_RDATA_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && hit_ram && !access_ok) |=> (cpu_rdata == 8'h00)); // R3
  AST_STALL_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (eop_access && !setup_evt) |=> !stall_req); // R10
endmodule

// File: tb/desc_ram_guard_bench.sv
module desc_ram_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        setup_evt = 1'b0;
  logic [7:0]  req_code = '0;
  logic        bus_reset = 1'b0, eop_access = 1'b0, init_cmd = 1'b0;
  logic        stall_req, reload_busy, init_done, ld_valid;
  logic [8:0]  ld_index;
  logic [7:0]  ld_data;

  int checks = 0;
  int errors = 0;
  int mon_idx = 0;
  logic [7:0] exp_mem [384];

  always #2.5 clk = ~clk;

  desc_ram_guard u_desc_ram_guard (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .setup_evt(setup_evt),
    .req_code(req_code), .bus_reset(bus_reset), .eop_access(eop_access),
    .init_cmd(init_cmd), .stall_req(stall_req), .reload_busy(reload_busy),
    .init_done(init_done), .ld_valid(ld_valid), .ld_index(ld_index), .ld_data(ld_data)
  );

  // {op(1=write,2=read), addr, wdata, expected read}
  localparam logic [33:0] VEC [11] = '{
    {2'd1, 16'h0500, 8'hA5, 8'h00},
    {2'd1, 16'h067F, 8'h3C, 8'h00},
    {2'd1, 16'h05A3, 8'h77, 8'h00},
    {2'd2, 16'h0500, 8'h00, 8'hA5},
    {2'd2, 16'h067F, 8'h00, 8'h3C},
    {2'd2, 16'h05A3, 8'h00, 8'h77},
    {2'd2, 16'h07E8, 8'h00, 8'h00},
    {2'd1, 16'h04FF, 8'h99, 8'h00},
    {2'd2, 16'h04FF, 8'h00, 8'h00},
    {2'd1, 16'h0680, 8'h12, 8'h00},
    {2'd2, 16'h0680, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); d = cpu_rdata; cpu_rd = 1'b0;
  endtask

  // which: 0 bus reset, 1 init command, 2 setup, 3 eop access
  task automatic strobe(input int which, input logic [7:0] code);
    @(negedge clk);
    case (which)
      0: bus_reset = 1'b1;
      1: init_cmd = 1'b1;
      2: begin setup_evt = 1'b1; req_code = code; end
      default: eop_access = 1'b1;
    endcase
    @(negedge clk);
    bus_reset = 1'b0; init_cmd = 1'b0; setup_evt = 1'b0; eop_access = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!init_done && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  // reload stream monitor (R5, R6)
  always @(negedge clk) begin
    if (!rst && ld_valid) begin
      if (ld_index == 9'd0) mon_idx = 0;
      chk(ld_index == 9'(mon_idx), "R5 index order", ld_index, mon_idx);
      chk(ld_data == exp_mem[mon_idx], "R5 reload data", ld_data, exp_mem[mon_idx]);
      mon_idx++;
    end
    if (!rst && init_done)
      chk(mon_idx == 384, "R6 done with last byte", mon_idx, 384);
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(stall_req == 1'b0 && reload_busy == 1'b0 && init_done == 1'b0 && ld_valid == 1'b0,
        "R1 reset outputs", {stall_req, reload_busy, init_done, ld_valid}, 0);
    chk(cpu_rdata == 8'h00, "R1 rdata reset", cpu_rdata, 0);

    // table: R2 RAM access before bus reset, R9 ctrl reset value, R11 unmapped
    for (int i = 0; i < 11; i++) begin
      if (VEC[i][33:32] == 2'd1) do_write(VEC[i][31:16], VEC[i][15:8]);
      else begin
        do_read(VEC[i][31:16], d);
        chk(d == VEC[i][7:0], $sformatf("R2/R9/R11 vector %0d", i), d, VEC[i][7:0]);
      end
    end

    for (int i = 0; i < 384; i++) begin
      exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      do_write(16'h0500 + 16'(i), exp_mem[i]);
    end
    do_read(16'h0600, d);
    chk(d == exp_mem[256], "R2 fill readback", d, exp_mem[256]);

    // R5/R7: bus reset reload with ignored command mid-way
    strobe(0, 8'h00);
    chk(reload_busy == 1'b1, "R7 busy after start", reload_busy, 1);
    repeat (50) @(negedge clk);
    chk(reload_busy == 1'b1, "R7 busy during reload", reload_busy, 1);
    strobe(1, 8'h00);
    wait_done(n);
    chk(n == 332, "R7 command while busy ignored", n, 332);
    @(negedge clk);
    chk(reload_busy == 1'b0 && init_done == 1'b0, "R6 pulse one cycle", {reload_busy, init_done}, 0);

    // R3: closed after bus reset
    do_write(16'h0500, 8'hEE);
    do_read(16'h0500, d);
    chk(d == 8'h00, "R3 read closed", d, 0);

    // R4: wrong code keeps closed, SET_DESCRIPTOR opens
    strobe(2, 8'h06);
    do_read(16'h0500, d);
    chk(d == 8'h00, "R4 other code closed", d, 0);
    strobe(2, 8'h07);
    chk(stall_req == 1'b0, "R10 no stall with bit 0", stall_req, 0);
    do_read(16'h0500, d);
    chk(d == exp_mem[0], "R3/R4 write ignored while closed, open reads", d, exp_mem[0]);
    do_write(16'h0500, 8'h5C);
    exp_mem[0] = 8'h5C;

    // R6/R8: init command, access during busy refused
    strobe(1, 8'h00);
    do_write(16'h0502, 8'h11);
    do_read(16'h0501, d);
    chk(d == 8'h00, "R8 read while busy", d, 0);
    wait_done(n);
    chk(n == 380, "R6 reload length", n, 380);
    do_read(16'h0502, d);
    chk(d == exp_mem[2], "R8 write while busy ignored", d, exp_mem[2]);
    strobe(3, 8'h00);
    do_read(16'h0500, d);
    chk(d == 8'h00, "R4 eop closes", d, 0);

    // R9/R10: auto-stall bit
    do_write(16'h07E8, 8'hFF);
    do_read(16'h07E8, d);
    chk(d == 8'h01, "R9 ctrl readback", d, 1);
    chk(stall_req == 1'b0, "R10 no stall outside window", stall_req, 0);
    strobe(2, 8'h07);
    chk(stall_req == 1'b1, "R10 stall in window", stall_req, 1);
    strobe(3, 8'h00);
    chk(stall_req == 1'b0, "R10 stall clears", stall_req, 0);

    // R11: bus reset restarts a running reload
    strobe(0, 8'h00);
    repeat (100) @(negedge clk);
    strobe(0, 8'h00);
    wait_done(n);
    chk(n == 384, "R11 restart from byte 0", n, 384);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule